// File: doc/BRIEF.md
# Multi-Depth Pixel Unpacker and Scaler

This block turns one fetched display byte into a run of screen pixels. The byte can hold eight 1-bit pixels, four 2-bit pixels or two 4-bit pixels. At 2 and 4 bits per pixel, the bits of one pixel are not adjacent. They are interleaved across the two nibbles, so each pixel takes one bit from each group of positions spaced by the pixel count. Each logical pixel value goes through a fixed 16-entry palette, which wraps every eight entries, to give a 3-bit RGB output. Each pixel is held on the output for 1, 2 or 4 clocks, set by a horizontal scale code.

A fetch unit presents a byte with a ready strobe. The unpacker takes the byte only when it is idle, and raises a busy flag for exactly as many clocks as the byte needs on screen. Depth and scale are latched together with the byte. A mode change arriving in the middle of a byte therefore takes effect only at the next byte. A blank request forces the output to black for row-gap lines without stopping the pixel timing.

Top module: `pixel_unpack`

## Requirements
- R1: With depth code 2'b00, the byte gives eight pixels. Pixel n (n = 0..7) is bit 7−n of the byte.
- R2: With depth code 2'b01, the byte gives four pixels. Pixel n (n = 0..3) has bit 7−n as its upper bit and bit 3−n as its lower bit.
- R3: With depth code 2'b10 or 2'b11, the byte gives two pixels. Pixel 0 is {b7,b5,b3,b1} and pixel 1 is {b6,b4,b2,b0}, most significant bit first.
- R4: A pixel value v drives rgbOut[0] (red) = v[0], rgbOut[1] (green) = v[1] and rgbOut[2] (blue) = v[2]. Values 8..15 give the same colour as v−8.
- R5: Each pixel stays on rgbOut for 1 clock with scale code 2'b00, 2 clocks with 2'b01 and 4 clocks with 2'b10 or 2'b11.
- R6: A byte is taken at a clock edge where busy is low and byteReady is high. From the next cycle, busy stays high for exactly (pixels per byte × scale) cycles and then falls. While busy is high, byteReady and pixByte are ignored.
- R7: depthSel and scaleSel are sampled only when a byte is taken. Changing them while busy is high does not alter the pixels still to be shown.
- R8: rgbOut is 0 whenever busy is low or blankReq is high. blankReq does not change how long busy stays high.
- R9: While rstN is low, busy is 0 and rgbOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| depthSel | input | 2 | Bits-per-pixel code: 00 = 1, 01 = 2, 1x = 4 |
| scaleSel | input | 2 | Clocks per pixel code: 00 = 1, 01 = 2, 1x = 4 |
| pixByte | input | 8 | Fetched display byte |
| byteReady | input | 1 | pixByte is valid and can be taken |
| blankReq | input | 1 | Force black output (row gap) |
| rgbOut | output | 3 | Pixel colour: bit 0 red, bit 1 green, bit 2 blue |
| busy | output | 1 | A byte is being emitted |

## Verification
A wrong pixel index or a wrong bit selection shows on rgbOut in the first cycle that the faulty pixel is on screen. For that reason, every emitted cycle of every byte is compared, at every depth and scale. A hold counter that reloads wrongly changes the number of cycles busy stays high. This is visible when the byte ends, and it also shifts every later pixel by a cycle. A setting that is sampled continuously instead of at load shows only when settings change in the middle of a byte, so one scenario changes depth, scale and byte while busy is high.

// File: rtl/pixel_unpack_pkg.sv
package pixel_unpack_pkg;
  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 3;
  localparam int VAL_W   = 4;
  localparam int COLOR_W = 3;

  typedef struct packed {
    logic             load;    // take a new byte this edge
    logic             emit;    // a pixel is on screen
    logic [IDX_W-1:0] pixIdx;  // which pixel of the held byte
  } strobes_t;
endpackage

// File: rtl/pixel_unpack_ctrl.sv
module pixel_unpack_ctrl
  import pixel_unpack_pkg::*;
#(
  parameter int HOLD_W = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] depthSel,
  input  logic [1:0] scaleSel,
  input  logic       byteReady,
  output strobes_t   strobes,
  output logic       busy
);
  logic [HOLD_W-1:0] holdCnt;
  logic [HOLD_W-1:0] holdReload;
  logic [IDX_W-1:0]  pixIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic [HOLD_W-1:0] newReload;
  logic [IDX_W-1:0]  newLast;
  logic              loadNow;

  assign loadNow = !busy && byteReady;

  always_comb begin
    case (scaleSel)
      2'b00:   newReload = HOLD_W'(0);
      2'b01:   newReload = HOLD_W'(1);
      default: newReload = HOLD_W'(3);
    endcase
    case (depthSel)
      2'b00:   newLast = IDX_W'(7);
      2'b01:   newLast = IDX_W'(3);
      default: newLast = IDX_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      holdCnt    <= '0;
      holdReload <= '0;
      pixIdx     <= '0;
      lastIdx    <= '0;
    end else if (loadNow) begin
      busy       <= 1'b1;
      holdCnt    <= newReload;
      holdReload <= newReload;
      pixIdx     <= '0;
      lastIdx    <= newLast;
    end else if (busy) begin
      if (holdCnt == '0) begin
        holdCnt <= holdReload;
        if (pixIdx == lastIdx) busy <= 1'b0;
        else                   pixIdx <= pixIdx + 1'b1;
      end else begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end

  assign strobes.load   = loadNow;
  assign strobes.emit   = busy;
  assign strobes.pixIdx = pixIdx;
endmodule

// File: rtl/pixel_unpack_dp.sv
module pixel_unpack_dp
  import pixel_unpack_pkg::*;
#(
  parameter int PAL_SIZE = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic [1:0]         depthSel,
  input  logic [BYTE_W-1:0]  pixByte,
  input  logic               blankReq,
  output logic [COLOR_W-1:0] rgbOut
);
  localparam int PAL_WRAP = 1 << COLOR_W;

  logic [BYTE_W-1:0]  byteReg;
  logic [1:0]         depthLat;
  logic [VAL_W-1:0]   pixVal;
  logic [COLOR_W-1:0] palette [PAL_SIZE];

  for (genvar i = 0; i < PAL_SIZE; i++) begin : g_pal
    assign palette[i] = COLOR_W'(i % PAL_WRAP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg  <= '0;
      depthLat <= '0;
    end else if (strobes.load) begin
      byteReg  <= pixByte;
      depthLat <= depthSel;
    end
  end

  always_comb begin
    int i;
    pixVal = '0;
    case (depthLat)
      2'b00: begin
        i = int'(strobes.pixIdx);
        pixVal = {3'b000, byteReg[7 - i]};
      end
      2'b01: begin
        i = int'(strobes.pixIdx[1:0]);
        pixVal = {2'b00, byteReg[7 - i], byteReg[3 - i]};
      end
      default: begin
        i = int'(strobes.pixIdx[0]);
        pixVal = {byteReg[7 - i], byteReg[5 - i], byteReg[3 - i], byteReg[1 - i]};
      end
    endcase
  end

  assign rgbOut = (strobes.emit && !blankReq) ? palette[pixVal] : '0;
endmodule

// File: rtl/pixel_unpack.sv
module pixel_unpack
  import pixel_unpack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] depthSel,
  input  logic [1:0] scaleSel,
  input  logic [7:0] pixByte,
  input  logic       byteReady,
  input  logic       blankReq,
  output logic [2:0] rgbOut,
  output logic       busy
);
  strobes_t strobes;

  pixel_unpack_ctrl #(.HOLD_W(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .depthSel(depthSel), .scaleSel(scaleSel),
    .byteReady(byteReady), .strobes(strobes), .busy(busy)
  );

  pixel_unpack_dp #(.PAL_SIZE(16)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .depthSel(depthSel),
    .pixByte(pixByte), .blankReq(blankReq), .rgbOut(rgbOut)
  );
endmodule

// File: rtl/pixel_unpack_chk.sv
module pixel_unpack_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] depthSel,
  input logic [1:0] scaleSel,
  input logic       byteReady,
  input logic       blankReq,
  input logic [2:0] rgbOut,
  input logic       busy
);
  logic [5:0] runCnt;
  logic [5:0] expLen;
  logic [5:0] lenNow;

  always_comb begin
    logic [5:0] ppb, sc;
    ppb = (depthSel == 2'b00) ? 6'd8 : (depthSel == 2'b01) ? 6'd4 : 6'd2;
    sc  = (scaleSel == 2'b00) ? 6'd1 : (scaleSel == 2'b01) ? 6'd2 : 6'd4;
    lenNow = 6'(ppb * sc);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      expLen <= '0;
    end else if (!busy && byteReady) begin
      runCnt <= '0;
      expLen <= lenNow;
    end else if (busy) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  p_reset_idle_r9: assert property (@(posedge clk) !rstN |-> (!busy && rgbOut == 3'd0));

  p_idle_black_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> rgbOut == 3'd0);

  p_blank_black_r8: assert property (@(posedge clk) disable iff (!rstN)
    blankReq |-> rgbOut == 3'd0);

  p_load_starts_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && byteReady) |=> busy);

  p_start_needs_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(byteReady));

  p_run_length_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runCnt == expLen);
endmodule

bind pixel_unpack pixel_unpack_chk u_chk (
  .clk(clk), .rstN(rstN), .depthSel(depthSel), .scaleSel(scaleSel),
  .byteReady(byteReady), .blankReq(blankReq), .rgbOut(rgbOut), .busy(busy)
);

// File: tb/sim_pixel_unpack.sv
`timescale 1ns/1ps
module sim_pixel_unpack;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] depthSel = 2'b00;
  logic [1:0] scaleSel = 2'b00;
  logic [7:0] pixByte = 8'h00;
  logic       byteReady = 1'b0;
  logic       blankReq = 1'b0;
  logic [2:0] rgbOut;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pixel_unpack u0 (
    .clk(clk), .rstN(rstN), .depthSel(depthSel), .scaleSel(scaleSel),
    .pixByte(pixByte), .byteReady(byteReady), .blankReq(blankReq),
    .rgbOut(rgbOut), .busy(busy)
  );

  function automatic int ppbOf(logic [1:0] d);
    return (d == 2'b00) ? 8 : (d == 2'b01) ? 4 : 2;
  endfunction

  function automatic int scaleOf(logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  // Pixel value from the requirement text, one depth at a time.
  function automatic logic [3:0] expVal(logic [7:0] b, logic [1:0] d, int n);
    logic [3:0] v;
    v = '0;
    if (d == 2'b00) v[0] = b[7 - n];
    else if (d == 2'b01) begin
      v[1] = b[7 - n];
      v[0] = b[3 - n];
    end else if (n == 0) v = {b[7], b[5], b[3], b[1]};
    else                 v = {b[6], b[4], b[2], b[0]};
    return v;
  endfunction

  function automatic logic [2:0] expRgb(logic [3:0] v);
    logic [2:0] c;
    c[0] = v[0];  // red
    c[1] = v[1];  // green
    c[2] = v[2];  // blue
    return c;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Offer a byte while idle, then check every emitted cycle.
  // Optionally disturb the inputs during emission or blank it.
  task automatic runByte(string req, logic [7:0] b, logic [1:0] d, logic [1:0] s,
                         bit disturb, bit blank);
    int len;
    len = ppbOf(d) * scaleOf(s);
    depthSel  = d;
    scaleSel  = s;
    pixByte   = b;
    byteReady = 1'b1;
    blankReq  = blank;
    @(negedge clk);
    if (!disturb) byteReady = 1'b0;
    else begin
      depthSel = ~d;
      scaleSel = ~s;
      pixByte  = ~b;
    end
    for (int c = 0; c < len; c++) begin
      check({req, " busy"}, 8'(busy), 8'd1);
      check(req, 8'(rgbOut), blank ? 8'd0 : 8'(expRgb(expVal(b, d, c / scaleOf(s)))));
      @(negedge clk);
    end
    byteReady = 1'b0;
    blankReq  = 1'b0;
    check({req, " busy end"}, 8'(busy), 8'd0);
    check({req, " idle black R8"}, 8'(rgbOut), 8'd0);
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R9 busy", 8'(busy), 8'd0);
    check("R9 rgb", 8'(rgbOut), 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle after release", 8'(busy), 8'd0);
  endtask

  task automatic testIdleReady();
    // R6: byteReady low, nothing starts
    byteReady = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 no start without ready", 8'(busy), 8'd0);
  endtask

  initial begin
    testReset();
    testIdleReady();
    runByte("R1 1bpp x1", 8'hA5, 2'b00, 2'b00, 0, 0);
    runByte("R1 1bpp x2", 8'h3C, 2'b00, 2'b01, 0, 0);
    runByte("R2 2bpp x2", 8'h9C, 2'b01, 2'b01, 0, 0);
    runByte("R2 2bpp x1", 8'h63, 2'b01, 2'b00, 0, 0);
    runByte("R3 4bpp x4", 8'hB4, 2'b10, 2'b10, 0, 0);
    runByte("R3 4bpp code11 x4 code11", 8'h5A, 2'b11, 2'b11, 0, 0);
    runByte("R4 palette wrap", 8'hFF, 2'b10, 2'b00, 0, 0);
    runByte("R4 palette high", 8'hAA, 2'b10, 2'b01, 0, 0);
    runByte("R5 scale4 1bpp", 8'h81, 2'b00, 2'b10, 0, 0);
    runByte("R7 settings latched", 8'hC6, 2'b01, 2'b01, 1, 0);
    runByte("R6 ready held ignored", 8'h4E, 2'b00, 2'b00, 1, 0);
    runByte("R8 blank", 8'hFF, 2'b00, 2'b01, 0, 1);
    runByte("R5 after blank", 8'h12, 2'b01, 2'b10, 0, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule